// File: doc/BRIEF.md
# Column-Sum Parallel Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. For every output column k it collects all bit pairs a[i]·b[j] with i+j equal to k and adds them up, with every column worked out in parallel. A single pass then walks the columns from the least significant upward. Each column keeps the low bit of its total as one product bit and hands the rest of the total, shifted right by one, to the next column. The whole structure is flat. It does not build a wide multiplier out of smaller multiplier instances.

The operand width is a parameter and is meant to be 2, 4, 8 or 16. A second parameter selects between a purely combinational result and one that passes through a single output register for timing. That register has an active-low asynchronous reset. The product is only a function of the operands, so the block holds no other state.

Top module: `ccm_mult`

## Requirements
- R1: When op_a has only bit i set and op_b has only bit j set, product has exactly bit i+j set. Every crosswise pair lands in the column given by the sum of its indices.
- R2: Carries ripple upward through every column. With op_a at all ones, product equals (2^N-1) times op_b, both for op_b at all ones and for op_b a single power of two. The carry left over after the top column fits in the single product MSB.
- R3: For every pair of operand values, product equals op_a*op_b as an unsigned 2N-bit value.
- R4: For N=2, product bits follow these formulas. p0 = a0&b0. p1 = (a1&b0)^(a0&b1). p2 = a1&b1&~(a0&b0). p3 = a1&a0&b1&b0.
- R5: When either operand is zero, product is zero.
- R6: With OUT_REG=1, product shows the operands that were present at the previous rising clock edge. A change in the operands between edges does not alter product. With OUT_REG=0, product follows the operands with no clock.
- R7: With OUT_REG=1, product is zero while rst_n is low, and asserting rst_n clears it at once without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| product | output | 2N | Unsigned product op_a*op_b |

## Verification
The bench builds four copies of the block. The 2-bit and 4-bit copies are combinational and are swept over every operand pair, so every bit formula of the smallest size and every carry pattern at 4 bits gets checked. An 8-bit copy with the output register is driven through all 65,536 pairs one per clock, which covers the one-cycle latency and the reset clear. A 16-bit combinational copy is driven with every single-bit pair, with all-ones and zero operands, and with random vectors, since that operand space is too large to sweep.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

    function automatic int col_terms(input int k, input int n);
        int lo_side;
        int hi_side;
        lo_side = k + 1;
        hi_side = 2 * n - 1 - k;
        return (lo_side < hi_side) ? lo_side : hi_side;
    endfunction

    function automatic int bits_for(input int v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int total_w(input int n);
        return $clog2(2 * n) + 1;
    endfunction

endpackage

// File: rtl/ccm_column.sv
module ccm_column #(
    parameter int N  = 8,
    parameter int K  = 0,
    parameter int SW = 1
) (
    input  logic [N-1:0]  a_i,
    input  logic [N-1:0]  b_i,
    output logic [SW-1:0] sum_o
);
    localparam int NT = ccm_pkg::col_terms(K, N);

    logic [N-1:0] term;

    for (genvar i = 0; i < N; i++) begin : g_term
        if ((K - i >= 0) && (K - i < N)) begin : g_hit
            assign term[i] = a_i[i] & b_i[K-i];
        end else begin : g_miss
            assign term[i] = 1'b0;
        end
    end

    always_comb begin
        sum_o = '0;
        for (int i = 0; i < N; i++) begin
            sum_o = sum_o + SW'(term[i]);
        end
    end

    // R1: a column never exceeds the number of crosswise pairs it owns
    always_comb begin
        a_r1_col_bound: assert (int'(sum_o) <= NT);
    end

endmodule

// File: rtl/ccm_carry.sv
module ccm_carry #(
    parameter int N  = 8,
    parameter int TW = 5
) (
    input  logic [2*N-2:0][TW-1:0] col_i,
    output logic [2*N-1:0]         prod_o
);
    logic [TW-1:0] carry;
    logic [TW-1:0] total;

    always_comb begin
        carry = '0;
        total = '0;
        prod_o = '0;
        for (int k = 0; k < 2 * N - 1; k++) begin
            total     = col_i[k] + carry;
            prod_o[k] = total[0];
            carry     = total >> 1;
        end
        prod_o[2*N-1] = carry[0];
    end

    // R2: what is left above the top column must fit in one bit
    always_comb begin
        a_r2_carry_top: assert (carry < TW'(2));
    end

endmodule

// File: rtl/ccm_mult.sv
module ccm_mult #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] product
);
    localparam int PW   = 2 * N;
    localparam int NCOL = 2 * N - 1;
    localparam int TW   = ccm_pkg::total_w(N);

    typedef struct packed {
        logic [PW-1:0] prod;
    } st_t;

    logic [NCOL-1:0][TW-1:0] col_sum;
    logic [PW-1:0]           comb_prod;
    st_t                     st_d;

    for (genvar k = 0; k < NCOL; k++) begin : g_col
        localparam int SW = ccm_pkg::bits_for(ccm_pkg::col_terms(k, N));
        logic [SW-1:0] s;
        ccm_column #(.N(N), .K(k), .SW(SW)) u_col (
            .a_i  (op_a),
            .b_i  (op_b),
            .sum_o(s)
        );
        assign col_sum[k] = TW'(s);
    end

    ccm_carry #(.N(N), .TW(TW)) u_carry (
        .col_i (col_sum),
        .prod_o(comb_prod)
    );

    always_comb begin
        st_d      = '0;
        st_d.prod = comb_prod;
    end

    if (OUT_REG) begin : g_reg
        st_t st_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
        assign product = st_q.prod;

        // R6: registered result is the product of last edge's operands
        a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> product == $past(op_a) * $past(op_b));
    end else begin : g_comb
        assign product = st_d.prod;
    end

    // R3: column sums plus carry pass equal the arithmetic product
    a_r3_exact: assert property (@(posedge clk) disable iff (!rst_n)
        comb_prod == op_a * op_b);

    // R5: a zero operand yields a zero product
    a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a == '0 || op_b == '0) |-> comb_prod == '0);

endmodule

// File: tb/ccm_mult_tb.sv
`timescale 1ns/1ps
module ccm_mult_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;

    logic [1:0]  a2, b2;   logic [3:0]  p2;
    logic [3:0]  a4, b4;   logic [7:0]  p4;
    logic [7:0]  a8, b8;   logic [15:0] p8;
    logic [15:0] a16, b16; logic [31:0] p16;

    ccm_mult #(.N(2), .OUT_REG(1'b0)) u_dut (.clk(clk), .rst_n(rst_n), .op_a(a2), .op_b(b2), .product(p2));
    ccm_mult #(.N(4), .OUT_REG(1'b0)) u_dut4 (.clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4), .product(p4));
    ccm_mult #(.N(8), .OUT_REG(1'b1)) u_dut8 (.clk(clk), .rst_n(rst_n), .op_a(a8), .op_b(b8), .product(p8));
    ccm_mult #(.N(16), .OUT_REG(1'b0)) u_dut16 (.clk(clk), .rst_n(rst_n), .op_a(a16), .op_b(b16), .product(p16));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #3000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [15:0] exp8;
        a2 = '0; b2 = '0; a4 = '0; b4 = '0; a8 = '0; b8 = '0; a16 = '0; b16 = '0;
        #2;
        // R7: product held at zero during reset
        a8 = 8'hff; b8 = 8'hff; #2;
        chk("R7 reset", 32'(p8), 32'h0);

        // R4 and R3 at N=2, every pair
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic [3:0] f;
                a2 = 2'(a); b2 = 2'(b); #2;
                f[0] = a2[0] & b2[0];
                f[1] = (a2[1] & b2[0]) ^ (a2[0] & b2[1]);
                f[2] = a2[1] & b2[1] & ~(a2[0] & b2[0]);
                f[3] = a2[1] & a2[0] & b2[1] & b2[0];
                chk("R4 2x2 bits", 32'(p2), 32'(f));
                chk("R3 N2", 32'(p2), 32'(a * b));
            end
        end

        // R3 at N=4, every pair
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                a4 = 4'(a); b4 = 4'(b); #2;
                chk("R3 N4", 32'(p4), 32'(a * b));
            end
        end

        // R1 single-bit placement at N=16
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                a16 = 16'(1) << i; b16 = 16'(1) << j; #2;
                chk("R1 placement", p16, 32'(1) << (i + j));
            end
        end

        // R2 carry ripple with all-ones operands
        a16 = 16'hffff; b16 = 16'hffff; #2;
        chk("R2 ones16", p16, 32'hfffe0001);
        a4 = 4'hf; b4 = 4'hf; #2;
        chk("R2 ones4", 32'(p4), 32'd225);
        for (int k = 0; k < 16; k++) begin
            a16 = 16'hffff; b16 = 16'(1) << k; #2;
            chk("R2 ones by pow2", p16, 32'(16'hffff) << k);
        end

        // R5 zero operands
        a16 = 16'h0; b16 = 16'hbeef; #2;
        chk("R5 zero a", p16, 32'h0);
        a16 = 16'hffff; b16 = 16'h0; #2;
        chk("R5 zero b", p16, 32'h0);

        // R3 random at N=16
        for (int n = 0; n < 3000; n++) begin
            a16 = 16'($urandom); b16 = 16'($urandom); #2;
            chk("R3 N16 random", p16, 32'(a16) * 32'(b16));
        end

        // R6 registered copy, every pair, one per clock
        @(negedge clk);
        rst_n = 1'b1;
        a8 = 8'h0; b8 = 8'h0; exp8 = 16'h0;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                @(negedge clk);
                chk("R6 N8 registered", 32'(p8), 32'(exp8));
                a8 = 8'(a); b8 = 8'(b); #1;
                chk("R6 held between edges", 32'(p8), 32'(exp8));
                exp8 = 16'(a * b);
            end
        end
        @(negedge clk);
        chk("R6 last pair", 32'(p8), 32'(exp8));

        // R7 asynchronous clear mid-run
        a8 = 8'hc3; b8 = 8'h5a;
        @(negedge clk);
        chk("R6 before clear", 32'(p8), 32'(16'hc3 * 16'h5a));
        #3 rst_n = 1'b0; #1;
        chk("R7 async clear", 32'(p8), 32'h0);

        summary();
    end
endmodule